// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the bit-level timing for an I2C controller. A prescaler divides the module clock by a programmable factor and produces a one-cycle internal tick. A phase sequencer counts those ticks to build each SCL period. It first holds SCL low, then releases it, and emits strobes for the byte controller: one marks where SDA may change, one marks where SDA is sampled, and one marks the end of a bit period.

Software writes a clock-control word directly. The divider field sits in the low bits. Its width is a parameter, 2 or 3 bits for the two supported variants. The 6-bit period-scale field sits directly above it. A separate input gives the rise/fall/internal-delay allowance, counted in internal ticks, because the block does not know the absolute clock frequency. The period is 20 ticks, plus eight ticks per unit of the scale field, plus the allowance. The controlling logic must keep the internal tick rate below 20 MHz. While SCL is released but another device still holds it low, the high-phase count waits.

Top module: `i2c_scl_timer`

## Requirements
- R1: While `run_i` is low, including directly after reset, `scl_low_o`, `tick_o`, `sda_chg_o`, `sample_o` and `period_end_o` are all 0.
- R2: While running, `tick_o` pulses once every (DIV+1) clocks. DIV is `clk_ctrl_i[CDF_W-1:0]`, so a bit period contains exactly P ticks.
- R3: One bit period lasts P = 20 + 8*SCALE + `comp_i` ticks. SCALE is `clk_ctrl_i[CDF_W+5:CDF_W]`. With no stretching, consecutive `period_end_o` pulses are P*(DIV+1) clocks apart.
- R4: Each period starts with a low phase of floor(P/2) ticks, during which `scl_low_o` is 1. The high phase takes the remaining ticks.
- R5: `sda_chg_o` pulses exactly once per period. It comes on the low-phase tick whose zero-based index is floor(low/2).
- R6: `sample_o` pulses exactly once per period. It comes on the high-phase tick whose zero-based count is floor(high/2), and `period_end_o` comes on the last high-phase tick.
- R7: During the high phase, a tick that arrives while `scl_in_i` is 0 does not advance the phase. Each such tick lengthens the period by one tick and delays `sample_o` by one tick.
- R8: During the low phase, `scl_in_i` has no effect on the timing.
- R9: `clk_ctrl_i` and `comp_i` are captured only while idle or on the `period_end_o` tick. A change made mid-period first affects the following period.
- R10: When `run_i` falls, all strobes are 0 in that same cycle, and `scl_low_o` is 0 from the next clock on.
- R11: The divider field width CDF_W is a parameter (2 or 3). The same control byte therefore decodes to different DIV and SCALE values in the two variants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Generate bit timing while high |
| clk_ctrl_i | input | CDF_W+6 | Divider field (low) and period-scale field (above it) |
| comp_i | input | COMP_W | Rise/fall/delay allowance in ticks |
| scl_in_i | input | 1 | SCL line as read back from the bus |
| tick_o | output | 1 | Internal clock enable |
| scl_low_o | output | 1 | Drive SCL low |
| sda_chg_o | output | 1 | SDA update point (mid-low) |
| sample_o | output | 1 | SDA sample point (mid-high) |
| period_end_o | output | 1 | Last tick of a bit period |

## Verification
The hardest case to reach is clock stretching. The bench must hold SCL low after the block has released it, and it must do so in line with the tick grid, so that a known number of high-phase ticks is suppressed. The bench models the bus as a wired-AND of the block's own drive and an external hold. It opens the hold on the first cycle SCL is released, and keeps it for a whole number of prescaler periods. The resulting extension of the period and the delayed sample point are then exact tick multiples. The bench also changes the configuration mid-period, to show that the change takes effect only at the next period boundary.

// File: rtl/i2c_scl_timer_pkg.sv
// Package: shared phase encoding and timing constants for the SCL generator.
// Assumes: consumers derive their counter widths from period_max().
package i2c_scl_timer_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

    // Fixed portion of every SCL period, in internal ticks.
    localparam int unsigned BASE_TICKS = 20;
    // The scale field is weighted by 8 ticks.
    localparam int unsigned SCALE_SHIFT = 3;

    // Longest period the fields can express.
    function automatic int unsigned period_max(int unsigned scale_w, int unsigned comp_w);
        return BASE_TICKS + (((1 << scale_w) - 1) << SCALE_SHIFT) + ((1 << comp_w) - 1);
    endfunction

endpackage

// File: rtl/sclgen_prescale.sv
// Module: first-stage divider. Emits a one-cycle tick every (div_i+1) clocks
// while enabled; restarts from zero whenever disabled.
// Assumes: div_i only changes on a tick cycle or while disabled.
module sclgen_prescale #(
    parameter int unsigned DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] pcnt_q;

    // Tick when the count reaches the programmed divider.
    assign tick_o = en_i && (pcnt_q == div_i);

    // Count clocks between ticks; clear on tick or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            pcnt_q <= '0;
        end else if (tick_o) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));

endmodule

// File: rtl/sclgen_period.sv
// Module: turns the latched scale and compensation values into the
// low-phase and high-phase lengths of one SCL period.
// Assumes: inputs are stable for the whole period (latched upstream).
module sclgen_period
    import i2c_scl_timer_pkg::*;
#(
    parameter int unsigned SCALE_W = 6,
    parameter int unsigned COMP_W  = 5,
    parameter int unsigned PER_W   = 10
) (
    input  logic [SCALE_W-1:0] scale_i,
    input  logic [COMP_W-1:0]  comp_i,
    output logic [PER_W-1:0]   low_len_o,
    output logic [PER_W-1:0]   high_len_o
);

    logic [PER_W-1:0] period;

    // Period = base + 8*scale + compensation; low gets the floor half.
    always_comb begin
        period     = PER_W'(BASE_TICKS)
                   + (PER_W'(scale_i) << SCALE_SHIFT)
                   + PER_W'(comp_i);
        low_len_o  = period >> 1;
        high_len_o = period - low_len_o;
    end

endmodule

// File: rtl/sclgen_phase.sv
// Module: SCL phase sequencer. Counts ticks through a low phase then a
// high phase, raising SDA-change, sample and period-end strobes. The high
// phase waits while the line is still read low (stretching).
// Assumes: low_len_i/high_len_i >= 10 and stable within a period.
module sclgen_phase
    import i2c_scl_timer_pkg::*;
#(
    parameter int unsigned PER_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             scl_in_i,
    input  logic [PER_W-1:0] low_len_i,
    input  logic [PER_W-1:0] high_len_i,
    output logic             active_o,
    output logic             scl_low_o,
    output logic             sda_chg_o,
    output logic             sample_o,
    output logic             period_end_o
);

    scl_phase_e       state_q;
    logic [PER_W-1:0] cnt_q;
    logic             low_last;
    logic             high_last;
    logic             high_step;

    // Decode phase-end points and whether the high phase may advance.
    always_comb begin
        low_last  = (cnt_q == low_len_i - PER_W'(1));
        high_last = (cnt_q == high_len_i - PER_W'(1));
        high_step = tick_i && scl_in_i;
    end

    // Output strobes, qualified by run so nothing leaks after a stop.
    always_comb begin
        active_o     = (state_q != PH_IDLE);
        scl_low_o    = (state_q == PH_LOW);
        sda_chg_o    = run_i && tick_i && (state_q == PH_LOW)
                       && (cnt_q == (low_len_i >> 1));
        sample_o     = run_i && high_step && (state_q == PH_HIGH)
                       && (cnt_q == (high_len_i >> 1));
        period_end_o = run_i && high_step && (state_q == PH_HIGH) && high_last;
    end

    // Phase state and tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                PH_IDLE: begin
                    state_q <= PH_LOW;
                    cnt_q   <= '0;
                end
                PH_LOW: begin
                    if (tick_i) begin
                        if (low_last) begin
                            state_q <= PH_HIGH;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                PH_HIGH: begin
                    if (high_step) begin
                        if (high_last) begin
                            state_q <= PH_LOW;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    state_q <= PH_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_LOW) |-> (cnt_q < low_len_i));

    // R4
    split_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (high_len_i >= low_len_i) && ((high_len_i - low_len_i) <= PER_W'(1)));

    // R4
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PH_IDLE && run_i && !tick_i) |=> $stable(state_q));

    // R7
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_HIGH && run_i && !scl_in_i) |=> $stable(cnt_q));

    // R10
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !scl_low_o);

endmodule

// File: rtl/i2c_scl_timer.sv
// Module: I2C SCL timing generator top. Latches the clock-control word and
// compensation at period boundaries, divides the clock into internal
// ticks and sequences the SCL low/high phases with their strobes.
// Assumes: software picks DIV so the tick rate stays below 20 MHz.
module i2c_scl_timer
    import i2c_scl_timer_pkg::*;
#(
    parameter int unsigned CDF_W   = 3,
    parameter int unsigned SCALE_W = 6,
    parameter int unsigned COMP_W  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run_i,
    input  logic [CDF_W+SCALE_W-1:0] clk_ctrl_i,
    input  logic [COMP_W-1:0]        comp_i,
    input  logic                     scl_in_i,
    output logic                     tick_o,
    output logic                     scl_low_o,
    output logic                     sda_chg_o,
    output logic                     sample_o,
    output logic                     period_end_o
);

    localparam int unsigned PER_MAX = period_max(SCALE_W, COMP_W);
    localparam int unsigned PER_W   = $clog2(PER_MAX + 1);

    logic [CDF_W-1:0]   div_q;
    logic [SCALE_W-1:0] scale_q;
    logic [COMP_W-1:0]  comp_q;
    logic               active;
    logic               period_end;
    logic               tick;
    logic               load_cfg;
    logic [PER_W-1:0]   low_len;
    logic [PER_W-1:0]   high_len;

    // Capture new settings only when idle or at the end of a period.
    assign load_cfg = !active || period_end;

    // Configuration latch: divider low, scale field directly above it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= '0;
            scale_q <= '0;
            comp_q  <= '0;
        end else if (load_cfg) begin
            div_q   <= clk_ctrl_i[CDF_W-1:0];
            scale_q <= clk_ctrl_i[CDF_W +: SCALE_W];
            comp_q  <= comp_i;
        end
    end

    sclgen_prescale #(
        .DIV_W (CDF_W)
    ) u_prescale (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (run_i && active),
        .div_i  (div_q),
        .tick_o (tick)
    );

    sclgen_period #(
        .SCALE_W (SCALE_W),
        .COMP_W  (COMP_W),
        .PER_W   (PER_W)
    ) u_period (
        .scale_i    (scale_q),
        .comp_i     (comp_q),
        .low_len_o  (low_len),
        .high_len_o (high_len)
    );

    sclgen_phase #(
        .PER_W (PER_W)
    ) u_phase (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run_i),
        .tick_i       (tick),
        .scl_in_i     (scl_in_i),
        .low_len_i    (low_len),
        .high_len_i   (high_len),
        .active_o     (active),
        .scl_low_o    (scl_low_o),
        .sda_chg_o    (sda_chg_o),
        .sample_o     (sample_o),
        .period_end_o (period_end)
    );

    assign tick_o       = tick;
    assign period_end_o = period_end;

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !period_end) |=> $stable({div_q, scale_q, comp_q}));

endmodule

// File: tb/test_i2c_scl_timer.sv
`timescale 1ns/1ps
module test_i2c_scl_timer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       run;
    logic [8:0] ctrl;
    logic [4:0] comp;
    logic       hold;
    logic       sel;

    logic tick_a, low_a, sda_a, smp_a, pe_a;
    logic tick_b, low_b, sda_b, smp_b, pe_b;
    logic scl_a, scl_b;
    logic o_tick, o_low, o_sda, o_smp, o_pe;

    int nchk  = 0;
    int nfail = 0;
    int cyc   = 0;
    bit done  = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Wired-AND bus: own drive plus an external device holding SCL low.
    assign scl_a = ~low_a & ~hold;
    assign scl_b = ~low_b & ~hold;

    assign o_tick = sel ? tick_b : tick_a;
    assign o_low  = sel ? low_b  : low_a;
    assign o_sda  = sel ? sda_b  : sda_a;
    assign o_smp  = sel ? smp_b  : smp_a;
    assign o_pe   = sel ? pe_b   : pe_a;

    i2c_scl_timer #(.CDF_W(3)) i_i2c_scl_timer (
        .clk(clk), .rst_n(rst_n), .run_i(run), .clk_ctrl_i(ctrl),
        .comp_i(comp), .scl_in_i(scl_a), .tick_o(tick_a), .scl_low_o(low_a),
        .sda_chg_o(sda_a), .sample_o(smp_a), .period_end_o(pe_a));

    i2c_scl_timer #(.CDF_W(2)) i_i2c_scl_timer_n2 (
        .clk(clk), .rst_n(rst_n), .run_i(run), .clk_ctrl_i(ctrl[7:0]),
        .comp_i(comp), .scl_in_i(scl_b), .tick_o(tick_b), .scl_low_o(low_b),
        .sda_chg_o(sda_b), .sample_o(smp_b), .period_end_o(pe_b));

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Advance to the next period-end strobe.
    task automatic wait_pe(input string tag);
        int k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!o_pe && k < 30000);
        if (k >= 30000) check({tag, " period end seen"}, 0, 1);
    endtask

    // From a period-end cycle (index 0), observe one period; hold SCL low
    // externally on indices [hs, hs+hl).
    task automatic measure(input int hs, input int hl,
                           output int plen, output int lowc, output int ticks,
                           output int nsda, output int sda_i,
                           output int nsmp, output int smp_i);
        int j = 0;
        plen = 0; lowc = 0; ticks = 0; nsda = 0; sda_i = 0; nsmp = 0; smp_i = 0;
        while (1) begin
            hold = (j >= hs) && (j < hs + hl);
            @(negedge clk);
            j++;
            if (o_tick) ticks++;
            if (o_low)  lowc++;
            if (o_sda) begin nsda++; sda_i = j; end
            if (o_smp) begin nsmp++; smp_i = j; end
            if (o_pe || j > 30000) break;
        end
        hold = 1'b0;
        plen = j;
    endtask

    // Steady-state timing for one configuration on the selected variant.
    task automatic t_timing(input string tag, input int raw, input int c, input bit var_b);
        int cdfw, dv, sc, d, p, lo, hi;
        int plen, lowc, ticks, nsda, sda_i, nsmp, smp_i;
        cdfw = var_b ? 2 : 3;
        dv   = raw & ((1 << cdfw) - 1);
        sc   = (raw >> cdfw) & 63;
        d    = dv + 1;
        p    = 20 + 8 * sc + c;
        lo   = p / 2;
        hi   = p - lo;
        sel  = var_b;
        ctrl = 9'(raw);
        comp = 5'(c);
        run  = 1'b1;
        wait_pe(tag);
        wait_pe(tag);
        measure(-1, 0, plen, lowc, ticks, nsda, sda_i, nsmp, smp_i);
        check({tag, " R3 period clocks"}, plen, p * d);
        check({tag, " R2 ticks per period"}, ticks, p);
        check({tag, " R4 low clocks"}, lowc, lo * d);
        check({tag, " R5 sda strobes"}, nsda, 1);
        check({tag, " R5 sda position"}, sda_i, (lo / 2 + 1) * d);
        check({tag, " R6 sample strobes"}, nsmp, 1);
        check({tag, " R6 sample position"}, smp_i, lo * d + (hi / 2 + 1) * d);
        run = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // R1: idle after reset with run low.
    task automatic t_reset();
        int act = 0;
        repeat (6) begin
            @(negedge clk);
            act += int'(low_a) + int'(tick_a) + int'(sda_a) + int'(smp_a) + int'(pe_a)
                 + int'(low_b) + int'(tick_b) + int'(sda_b) + int'(smp_b) + int'(pe_b);
        end
        check("R1 idle outputs quiet", act, 0);
    endtask

    // R7: external stretch during the high phase.
    task automatic t_stretch();
        int plen, lowc, ticks, nsda, sda_i, nsmp, smp_i;
        sel = 1'b0; ctrl = 9'd1; comp = 5'd0; run = 1'b1;   // DIV=1, P=20, d=2
        wait_pe("R7");
        wait_pe("R7");
        measure(21, 6, plen, lowc, ticks, nsda, sda_i, nsmp, smp_i);
        check("R7 stretched period", plen, 46);
        check("R7 sample delayed", smp_i, 38);
        check("R7 one sample", nsmp, 1);
        check("R7 low unchanged", lowc, 20);
        run = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // R8: holding the line during the low phase changes nothing.
    task automatic t_low_hold();
        int plen, lowc, ticks, nsda, sda_i, nsmp, smp_i;
        sel = 1'b0; ctrl = 9'd1; comp = 5'd0; run = 1'b1;
        wait_pe("R8");
        wait_pe("R8");
        measure(2, 5, plen, lowc, ticks, nsda, sda_i, nsmp, smp_i);
        check("R8 period unchanged", plen, 40);
        check("R8 sda position", sda_i, 12);
        check("R8 sample position", smp_i, 32);
        run = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // R9: mid-period reconfiguration applies from the next period.
    task automatic t_reconfig();
        int j;
        int plen, lowc, ticks, nsda, sda_i, nsmp, smp_i;
        sel = 1'b0; ctrl = 9'd2; comp = 5'd0; run = 1'b1;   // d=3, P=20
        wait_pe("R9");
        wait_pe("R9");
        j = 0;
        repeat (3) begin @(negedge clk); j++; end
        ctrl = 9'd9; comp = 5'd4;                           // d=2, P=32
        do begin
            @(negedge clk);
            j++;
        end while (!o_pe && j < 30000);
        check("R9 current period keeps old setting", j, 60);
        measure(-1, 0, plen, lowc, ticks, nsda, sda_i, nsmp, smp_i);
        check("R9 next period uses new setting", plen, 64);
        check("R9 new tick count", ticks, 32);
        run = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // R10: stopping mid-low releases SCL and silences strobes.
    task automatic t_stop();
        int act = 0;
        sel = 1'b0; ctrl = 9'd0; comp = 5'd0; run = 1'b1;
        wait_pe("R10");
        repeat (5) @(negedge clk);
        check("R10 driving low before stop", int'(o_low), 1);
        run = 1'b0;
        repeat (4) begin
            @(negedge clk);
            act += int'(o_low) + int'(o_tick) + int'(o_sda) + int'(o_smp) + int'(o_pe);
        end
        check("R10 quiet after stop", act, 0);
    endtask

    initial begin
        rst_n = 1'b0; run = 1'b0; ctrl = '0; comp = '0; hold = 1'b0; sel = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_timing("base", 0, 0, 1'b0);
        t_timing("mid", (2 << 3) | 3, 5, 1'b0);
        t_timing("max", 9'h1FF, 31, 1'b0);
        // R11: the same control byte decodes differently per field width
        t_timing("R11 wide-div", 6, 2, 1'b0);
        t_timing("R11 narrow-div", 6, 2, 1'b1);
        t_stretch();
        t_low_hold();
        t_reconfig();
        t_stop();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    // Watchdog: a hung run is reported as a failed check.
    always @(negedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule